// File: doc/BRIEF.md
# Pipelined Burst-Capable Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Each word is made of byte lanes, and each lane carries eight data bits plus one parity bit. With the default parameters a word is 36 bits wide and the array holds 64 words; the depth is set by a parameter. Every control and data input is captured on the rising clock edge. A read returns its word through an output register. Output gating and sleep act on the output at once, with no clock edge needed.

An access starts with one of two address strobes.
- **Processor strobe:** it counts only while the first chip select is low, and its start cycle is always a read.
- **Controller strobe:** it always counts, and its start cycle may also write.

Either strobe loads a new base address and a new select state. On the following cycles, a two-bit counter steps the low address bits in linear order with wrap-around. The counter advances only when the advance input is active. This gives one slow address cycle followed by fast beats.

Writes can cover all lanes through a global write. They can also cover only chosen lanes through a byte-write enable together with per-lane strobes. A strobe seen with any chip select false deselects the block in that same cycle.

Top module: `burst_sram`

## Requirements
- R1: Inputs are captured on the rising clock edge. The base address and the select state change only on a cycle where a strobe is accepted. The `addr` input is ignored on every other cycle.
- R2: `strobe_cpu_n` low is accepted only when `cs1_n` is low. With `cs1_n` high it is ignored: no access starts, and a running burst carries on unchanged.
- R3: An access started by the processor strobe is always a read, whatever the write controls say.
- R4: On each cycle of an active burst with no accepted strobe, `adv_n` low steps a 2-bit counter. The access address is the base with its two low bits replaced by (base low bits + counter) mod 4, so a base ending in 2 gives the order 2,3,0,1. With `adv_n` high, the same address is accessed again.
- R5: A read captured on edge k drives its word on `dout`, with `dout_vld` high, after edge k+1.
- R6: With `we_all_n` low (and no processor strobe start), all lanes are written. Lane i takes `din[9i+8:9i]`.
- R7: With `we_all_n` high and `we_en_n` low, only the lanes i whose `lane_we_n[i]` is low are written; the other lanes keep their contents. With `we_en_n` high, or with no lane selected, the cycle is a read.
- R8: A write captured on one edge is in the array before the next access. A read of the same address on the next beat returns the new data.
- R9: A strobe seen with `cs1_n`=0, `cs2`=1, `cs3_n`=0 not all true ends the burst in that cycle, and no access happens. `dout_vld` falls after the next edge and stays low until a new access.
- R10: `oe_n` high forces `dout_vld` low and `dout` to zero at once, with no clock edge.
- R11: While `sleep` is high, clock edges do nothing: no input is captured, the array is unchanged, the pipeline holds, and `dout_vld` is low. Work resumes on the first edge after `sleep` falls.
- R12: After reset no burst is active and `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, taken only when a strobe is accepted |
| din | input | LANES*LANE_W | Write data, one 9-bit field per lane |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| dout_vld | output | 1 | High when `dout` carries a read word |
| cs1_n | input | 1 | Chip select one, active low; also qualifies the processor strobe |
| cs2 | input | 1 | Chip select two, active high |
| cs3_n | input | 1 | Chip select three, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_all_n | input | 1 | Global write of all lanes, active low |
| we_en_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| sleep | input | 1 | Low-power state, active high |

## Verification
On every cycle the bound checker enforces several rules:
- a processor strobe blocked by `cs1_n` causes no access;
- a processor start is never a write;
- a strobe with a false select leaves no access and no burst;
- a sleeping edge holds the pipeline;
- a captured read is valid one edge later;
- a burst address steps or repeats according to `adv_n`.

Lane masking, the wrap order of the returned data, write-then-read ordering, output gating without a clock, and resuming after sleep can only be shown by the bench. It drives these sequences and compares every cycle against its own memory model.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Width of the burst counter; fixes a burst at four beats.
    localparam int BURST_CNT_W = 2;

    // True when all three chip selects are in their active state.
    function automatic logic chip_selected(input logic sel1_n, input logic sel2, input logic sel3_n);
        return (!sel1_n) && sel2 && (!sel3_n);
    endfunction

endpackage

// File: rtl/bsram_burst_ctl.sv
module bsram_burst_ctl #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              start_cpu_i,
    input  logic              start_ctl_i,
    input  logic              sel_i,
    input  logic              adv_i,
    output logic              go_o,
    output logic              cpu_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              active_o
);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
    } burst_t;

    burst_t st_d, st_q;
    logic [CNT_W-1:0] low_sum;

    always_comb begin
        st_d  = st_q;
        go_o  = 1'b0;
        cpu_o = 1'b0;
        if (!hold) begin
            if (start_cpu_i || start_ctl_i) begin
                if (sel_i) begin
                    st_d.active = 1'b1;
                    st_d.base   = addr_i;
                    st_d.cnt    = '0;
                    go_o        = 1'b1;
                    cpu_o       = start_cpu_i;
                end else begin
                    st_d.active = 1'b0;
                end
            end else if (st_q.active) begin
                if (adv_i) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                go_o = 1'b1;
            end
        end
        low_sum    = st_d.base[CNT_W-1:0] + st_d.cnt;
        acc_addr_o = {st_d.base[ADDR_W-1:CNT_W], low_sum};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

endmodule

// File: rtl/bsram_lane_dec.sv
module bsram_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             we_all_n,
    input  logic             we_en_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic             wr_o,
    output logic [LANES-1:0] mask_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask_o[g] = (!we_all_n) || ((!we_en_n) && (!lane_we_n[g]));
    end

    assign wr_o = |mask_o;

endmodule

// File: rtl/bsram_store.sv
module bsram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    rd_i,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] data_i,
    input  logic [LANES-1:0]        mask_i,
    output logic [LANES*LANE_W-1:0] q_o,
    output logic                    vld_o
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] q;
    } oreg_t;

    logic [WORD_W-1:0] mem [DEPTH];
    oreg_t o_d, o_q;

    // Write commit: the edge after the write was captured.
    always_ff @(posedge clk) begin
        if (!hold && wr_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask_i[l]) begin
                    mem[addr_i][l*LANE_W +: LANE_W] <= data_i[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_comb begin
        o_d = o_q;
        if (!hold) begin
            o_d.vld = rd_i;
            if (rd_i) begin
                o_d.q = mem[addr_i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign q_o   = o_q.q;
    assign vld_o = o_q.vld;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    adv_n,
    input  logic                    we_all_n,
    input  logic                    we_en_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic                    sleep
);

    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  mask;
    } stage_t;

    stage_t stg_d, stg_q;

    logic              go, cpu_start, active;
    logic [ADDR_W-1:0] acc_addr;
    logic              lane_wr;
    logic [LANES-1:0]  lane_mask;
    logic [WORD_W-1:0] rd_word;
    logic              out_vld;

    // Names seen by the bound checker.
    logic              stg_rd, stg_wr;
    logic [ADDR_W-1:0] stg_addr;

    bsram_burst_ctl #(
        .ADDR_W(ADDR_W),
        .CNT_W (BURST_CNT_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (sleep),
        .addr_i     (addr),
        .start_cpu_i(!strobe_cpu_n && !cs1_n),
        .start_ctl_i(!strobe_ctl_n),
        .sel_i      (chip_selected(cs1_n, cs2, cs3_n)),
        .adv_i      (!adv_n),
        .go_o       (go),
        .cpu_o      (cpu_start),
        .acc_addr_o (acc_addr),
        .active_o   (active)
    );

    bsram_lane_dec #(.LANES(LANES)) u_lanes (
        .we_all_n (we_all_n),
        .we_en_n  (we_en_n),
        .lane_we_n(lane_we_n),
        .wr_o     (lane_wr),
        .mask_o   (lane_mask)
    );

    always_comb begin
        stg_d = stg_q;
        if (!sleep) begin
            stg_d.wr   = go && lane_wr && !cpu_start;
            stg_d.rd   = go && !(lane_wr && !cpu_start);
            stg_d.addr = acc_addr;
            stg_d.data = din;
            stg_d.mask = lane_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    bsram_store #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (sleep),
        .rd_i  (stg_q.rd),
        .wr_i  (stg_q.wr),
        .addr_i(stg_q.addr),
        .data_i(stg_q.data),
        .mask_i(stg_q.mask),
        .q_o   (rd_word),
        .vld_o (out_vld)
    );

    assign stg_rd   = stg_q.rd;
    assign stg_wr   = stg_q.wr;
    assign stg_addr = stg_q.addr;

    assign dout_vld = out_vld && !oe_n && !sleep;
    assign dout     = dout_vld ? rd_word : '0;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              strobe_cpu_n,
    input logic              strobe_ctl_n,
    input logic              adv_n,
    input logic              active,
    input logic              stg_rd,
    input logic              stg_wr,
    input logic [ADDR_W-1:0] stg_addr,
    input logic              out_vld
);

    logic cpu_ok, any_start, sel_all;
    assign cpu_ok    = !strobe_cpu_n && !cs1_n;
    assign any_start = cpu_ok || !strobe_ctl_n;
    assign sel_all   = !cs1_n && cs2 && !cs3_n;

    assert_cpu_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !active && strobe_ctl_n && !strobe_cpu_n && cs1_n) |=> (!stg_rd && !stg_wr));

    assert_cpu_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && cpu_ok) |=> !stg_wr);

    assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && any_start && !sel_all) |=> (!active && !stg_rd && !stg_wr));

    assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(stg_addr) && $stable(stg_rd) && $stable(stg_wr) && $stable(out_vld)));

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && stg_rd) |=> out_vld);

    assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && active && !any_start && !adv_n) |=>
        ((stg_addr[CNT_W-1:0] == $past(stg_addr[CNT_W-1:0]) + 1'b1) &&
         (stg_addr[ADDR_W-1:CNT_W] == $past(stg_addr[ADDR_W-1:CNT_W]))));

    assert_burst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && active && !any_start && adv_n) |=> $stable(stg_addr));

endmodule

bind burst_sram bsram_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .cs1_n       (cs1_n),
    .cs2         (cs2),
    .cs3_n       (cs3_n),
    .strobe_cpu_n(strobe_cpu_n),
    .strobe_ctl_n(strobe_ctl_n),
    .adv_n       (adv_n),
    .active      (active),
    .stg_rd      (stg_rd),
    .stg_wr      (stg_wr),
    .stg_addr    (stg_addr),
    .out_vld     (out_vld)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;

    localparam int CLK_P  = 10;
    localparam int AW     = 6;
    localparam int DEPTH  = 1 << AW;
    localparam int NL     = 4;
    localparam int LW     = 9;
    localparam int WW     = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [WW-1:0] din;
    logic [WW-1:0] dout;
    logic          dout_vld;
    logic          cs1_n, cs2, cs3_n;
    logic          strobe_cpu_n, strobe_ctl_n, adv_n;
    logic          we_all_n, we_en_n;
    logic [NL-1:0] lane_we_n;
    logic          oe_n, sleep;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    string cur_req = "R12";

    always #(CLK_P/2) clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
        .dout_vld(dout_vld), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
        .we_all_n(we_all_n), .we_en_n(we_en_n), .lane_we_n(lane_we_n),
        .oe_n(oe_n), .sleep(sleep)
    );

    function automatic logic [WW-1:0] pat(input int a);
        logic [31:0] v;
        v = 32'h1357_9BDF + 32'(a) * 32'h0101_0103;
        return {4'(a) ^ 4'h9, v};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference, compared every clock ----------------
    logic [WW-1:0] m_mem [DEPTH];
    bit            m_active;
    int            m_base, m_cnt;
    bit            p_rd, p_wr;
    int            p_addr;
    logic [WW-1:0] p_data;
    logic [NL-1:0] p_mask;
    bit            o_vld;
    logic [WW-1:0] o_data;

    always @(posedge clk) begin
        bit go, cpu, ctl, sel, isw;
        int a;
        if (!rst_n) begin
            m_active = 0; m_base = 0; m_cnt = 0;
            p_rd = 0; p_wr = 0; o_vld = 0;
        end else if (!sleep) begin
            if (p_wr) begin
                for (int l = 0; l < NL; l++)
                    if (p_mask[l]) m_mem[p_addr][l*LW +: LW] = p_data[l*LW +: LW];
            end
            o_vld = p_rd;
            if (p_rd) o_data = m_mem[p_addr];
            go  = 0;
            cpu = !strobe_cpu_n && !cs1_n;
            ctl = !strobe_ctl_n;
            sel = !cs1_n && cs2 && !cs3_n;
            if (cpu || ctl) begin
                if (sel) begin m_active = 1; m_base = int'(addr); m_cnt = 0; go = 1; end
                else m_active = 0;
            end else if (m_active) begin
                if (!adv_n) m_cnt = (m_cnt + 1) % 4;
                go = 1;
            end
            a   = (m_base / 4) * 4 + ((m_base + m_cnt) % 4);
            isw = go && !cpu && (!we_all_n || (!we_en_n && lane_we_n != '1));
            p_rd = go && !isw;
            p_wr = isw;
            p_addr = a;
            p_data = din;
            p_mask = !we_all_n ? '1 : ~lane_we_n;
        end
        #2;
        begin
            bit ev;
            ev = o_vld && !oe_n && !sleep;
            chk(dout_vld == ev, {cur_req, " vld"}, {35'd0, dout_vld}, {35'd0, ev});
            if (ev && !$isunknown(o_data))
                chk(dout === o_data, {cur_req, " data"}, dout, o_data);
        end
    end

    task automatic idle_in();
        addr = '0; din = '0;
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
        we_all_n = 1'b1; we_en_n = 1'b1; lane_we_n = '1;
    endtask

    task automatic beat();
        @(negedge clk);
    endtask

    task automatic deselect();
        idle_in(); cs2 = 1'b0; strobe_ctl_n = 1'b0; beat();
        idle_in(); beat(); beat();
    endtask

    task automatic start_read(input int a);
        idle_in(); strobe_ctl_n = 1'b0; addr = AW'(a); beat();
        idle_in();
    endtask

    initial begin
        logic [WW-1:0] expw;
        idle_in(); oe_n = 1'b0; sleep = 1'b0; rst_n = 1'b0;
        repeat (3) beat();
        // R12: reset state
        chk(dout_vld == 1'b0, "R12", {35'd0, dout_vld}, '0);
        rst_n = 1'b1;
        beat();

        // R6: fill every word with global write bursts
        cur_req = "R6";
        for (int g = 0; g < DEPTH / 4; g++) begin
            idle_in(); strobe_ctl_n = 1'b0; addr = AW'(4*g); we_all_n = 1'b0; din = pat(4*g); beat();
            for (int j = 1; j < 4; j++) begin
                idle_in(); adv_n = 1'b0; we_all_n = 1'b0; din = pat(4*g + j); beat();
            end
        end
        // R9: deselect ends the burst
        cur_req = "R9";
        idle_in(); cs2 = 1'b0; strobe_ctl_n = 1'b0; beat();
        idle_in(); beat(); beat();
        chk(dout_vld == 1'b0, "R9", {35'd0, dout_vld}, '0);
        adv_n = 1'b0; beat();
        chk(dout_vld == 1'b0, "R9 held", {35'd0, dout_vld}, '0);

        // R4/R5: linear wrap from a base ending in 2
        cur_req = "R4";
        start_read(22);
        adv_n = 1'b0; beat();
        chk(dout === pat(22), "R5", dout, pat(22));
        beat(); chk(dout === pat(23), "R4", dout, pat(23));
        beat(); chk(dout === pat(20), "R4 wrap", dout, pat(20));
        beat(); chk(dout === pat(21), "R4", dout, pat(21));
        deselect();

        // R1: address ignored without a strobe; R4 hold repeats
        cur_req = "R1";
        start_read(12);
        addr = AW'(63); adv_n = 1'b1; beat();
        beat(); chk(dout === pat(12), "R1", dout, pat(12));
        beat(); chk(dout === pat(12), "R4 hold", dout, pat(12));
        deselect();

        // R7/R8: every lane combination on word 40
        cur_req = "R7";
        expw = pat(40);
        for (int m = 0; m < 16; m++) begin
            idle_in(); strobe_ctl_n = 1'b0; addr = AW'(40); we_en_n = 1'b0;
            lane_we_n = ~4'(m); din = pat(100 + m); beat();
            for (int l = 0; l < NL; l++)
                if (m[l]) expw[l*LW +: LW] = pat(100 + m)[l*LW +: LW];
            idle_in(); beat(); beat();
            chk(dout === expw, "R8 lane write then read", dout, expw);
        end
        // R7: lane strobes without the byte-write enable do nothing
        idle_in(); strobe_ctl_n = 1'b0; addr = AW'(40); lane_we_n = '0; din = '0; beat();
        idle_in(); beat(); beat();
        chk(dout === expw, "R7 no enable", dout, expw);
        deselect();

        // R3: processor start never writes
        cur_req = "R3";
        idle_in(); strobe_cpu_n = 1'b0; addr = AW'(41); we_all_n = 1'b0; din = '0; beat();
        idle_in(); beat(); beat();
        chk(dout === pat(41), "R3", dout, pat(41));

        // R2: processor strobe with cs1_n high is ignored, burst continues
        cur_req = "R2";
        idle_in(); cs1_n = 1'b1; strobe_cpu_n = 1'b0; addr = AW'(50); beat();
        idle_in(); beat();
        chk(dout === pat(41), "R2 burst kept", dout, pat(41));
        deselect();
        idle_in(); cs1_n = 1'b1; strobe_cpu_n = 1'b0; addr = AW'(50); beat();
        idle_in(); beat(); beat();
        chk(dout_vld == 1'b0, "R2 no start", {35'd0, dout_vld}, '0);

        // R10: output enable acts without a clock
        cur_req = "R10";
        start_read(8);
        beat();
        oe_n = 1'b1; #1;
        chk(dout_vld == 1'b0 && dout == '0, "R10 off", dout, '0);
        oe_n = 1'b0; #1;
        chk(dout_vld == 1'b1 && dout === pat(8), "R10 on", dout, pat(8));

        // R11: sleep ignores edges
        cur_req = "R11";
        sleep = 1'b1; strobe_ctl_n = 1'b0; addr = AW'(9); we_all_n = 1'b0; din = '0; #1;
        chk(dout_vld == 1'b0, "R11 gated", {35'd0, dout_vld}, '0);
        repeat (3) beat();
        sleep = 1'b0; idle_in(); beat();
        chk(dout === pat(8), "R11 resume", dout, pat(8));
        deselect();
        start_read(9);
        beat();
        chk(dout === pat(9), "R11 no write", dout, pat(9));
        deselect();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule